// File: doc/BRIEF.md
# DMA Element Address Generator

This block works out, for one DMA channel, the source and destination byte addresses of every element that the channel moves. A start pulse captures the channel setup: both start addresses, the element size, one addressing mode per side, signed per-element and per-frame offsets for each side, the number of elements in a frame and the number of frames in the block. After the start pulse, each element-done handshake from the transfer engine moves both addresses on to the next element, and the block tracks frame and block progress.

The source side and the destination side each use their own mode. In fixed mode the address never moves. In increment mode it moves by the element size. In indexed mode it moves by an element offset inside a frame and by a frame offset when a frame completes. One-cycle pulses report each completed frame and the completed block. Two sticky flags report a start address that is not aligned to the element size. Bus transfer, channel arbitration and register access live elsewhere.

Top module: `dma_addr_gen`

## Requirements
- R1: A cycle with `start_i` high loads `src_start_i` and `dst_start_i` into `src_addr_o` and `dst_addr_o` and sets `active_o` at the next clock edge. A start while a block is running restarts the block from the new setup.
- R2: Each side takes its own mode code: 2'b00 fixed, 2'b01 increment, 2'b10 indexed, 2'b11 behaves as fixed. The mode of one side has no effect on the other side.
- R3: In fixed mode the side's address does not change for any element of the block.
- R4: In increment mode the side's address grows by the element size after every element, frame boundaries included. The size code 2'b00, 2'b01, 2'b10 or 2'b11 means 1, 2, 4 or 8 bytes.
- R5: In indexed mode, an element that is not the last of its frame adds that side's 16-bit two's-complement element offset, sign-extended to 32 bits.
- R6: In indexed mode, the last element of a frame (other than the last frame) adds that side's sign-extended frame offset in place of the element offset.
- R7: `frame_end_o` is high for exactly the one cycle after the element-done that completes a frame, the final frame included.
- R8: After the element-done for the last element of the last frame, `block_end_o` pulses for one cycle, `active_o` drops in that same cycle, and both addresses keep the values of the final element.
- R9: An element count or frame count of zero is treated as one.
- R10: One cycle after a start, `src_misalign_o` or `dst_misalign_o` is high when that start address has any bit set below the element size. The flag holds its value until the next start.
- R11: Addresses, counters and flags change only on a clock edge with `elem_done_i` high while active, or on a start. An `elem_done_i` while idle has no effect.
- R12: All setup inputs are sampled only in the start cycle. Changing them during a block has no effect on that block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; captures the setup |
| src_start_i | input | 32 | Source start address |
| dst_start_i | input | 32 | Destination start address |
| elem_size_i | input | 2 | Element size code (1, 2, 4 or 8 bytes) |
| src_mode_i | input | 2 | Source addressing mode |
| dst_mode_i | input | 2 | Destination addressing mode |
| src_elem_ofs_i | input | 16 | Source signed element offset |
| src_frame_ofs_i | input | 16 | Source signed frame offset |
| dst_elem_ofs_i | input | 16 | Destination signed element offset |
| dst_frame_ofs_i | input | 16 | Destination signed frame offset |
| elem_cnt_i | input | 13 | Elements per frame (0 means 1) |
| frame_cnt_i | input | 13 | Frames per block (0 means 1) |
| elem_done_i | input | 1 | Element-done handshake |
| src_addr_o | output | 32 | Current source address |
| dst_addr_o | output | 32 | Current destination address |
| active_o | output | 1 | Block in progress |
| frame_end_o | output | 1 | One-cycle pulse when a frame completes |
| block_end_o | output | 1 | One-cycle pulse when the block completes |
| src_misalign_o | output | 1 | Source start address not aligned to element size |
| dst_misalign_o | output | 1 | Destination start address not aligned to element size |

## Verification
The bench sweeps every element size against every pair of source and destination modes, reserved code included. It uses negative and positive offsets on each side, so a design that swaps sides, fails to sign-extend, or applies the element offset at a frame boundary ends up at a wrong address on the first frame crossing. Zero counts, single-element frames and a restart in the middle of a block target the counter edges. A design that is off by one there would move an address on the final element, or skip or repeat the frame and block pulses. After every start the bench scrambles all setup inputs, feeds element-done pulses while idle, and checks the misalignment flags at every size, so that late sampling or stray updates show up at the ports.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;

    typedef enum logic [1:0] {
        AM_FIXED = 2'b00,
        AM_INCR  = 2'b01,
        AM_INDEX = 2'b10,
        AM_RSVD  = 2'b11
    } addr_mode_e;

endpackage

// File: rtl/dma_ag_side.sv
module dma_ag_side
    import dma_ag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [1:0]        mode_i,
    input  logic [1:0]        size_i,
    input  logic [OFS_W-1:0]  elem_ofs_i,
    input  logic [OFS_W-1:0]  frame_ofs_i,
    input  logic              step_i,
    input  logic              frame_step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              misalign_o
);
    localparam int EXT_W = ADDR_W - OFS_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        addr_mode_e        mode;
        logic [1:0]        size;
        logic [OFS_W-1:0]  eofs;
        logic [OFS_W-1:0]  fofs;
        logic              misalign;
    } side_t;

    side_t             d, q;
    logic [ADDR_W-1:0] step_amt;
    logic [ADDR_W-1:0] start_mask;

    always_comb begin
        d          = q;
        start_mask = (ADDR_W'(1) << size_i) - ADDR_W'(1);
        case (q.mode)
            AM_INCR:  step_amt = ADDR_W'(1) << q.size;
            AM_INDEX: step_amt = frame_step_i ? {{EXT_W{q.fofs[OFS_W-1]}}, q.fofs}
                                              : {{EXT_W{q.eofs[OFS_W-1]}}, q.eofs};
            default:  step_amt = '0;
        endcase
        if (start_i) begin
            d.addr     = start_addr_i;
            d.mode     = addr_mode_e'(mode_i);
            d.size     = size_i;
            d.eofs     = elem_ofs_i;
            d.fofs     = frame_ofs_i;
            d.misalign = |(start_addr_i & start_mask);
        end else if (step_i) begin
            d.addr = q.addr + step_amt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign addr_o     = q.addr;
    assign misalign_o = q.misalign;

endmodule

// File: rtl/dma_ag_seq.sv
module dma_ag_seq #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] elem_cnt_i,
    input  logic [CNT_W-1:0] frame_cnt_i,
    input  logic             done_i,
    output logic             active_o,
    output logic             step_o,
    output logic             frame_step_o,
    output logic             frame_end_o,
    output logic             block_end_o
);
    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] eidx;
        logic [CNT_W-1:0] fidx;
        logic [CNT_W-1:0] elast;
        logic [CNT_W-1:0] flast;
        logic             frame_end;
        logic             block_end;
    } seq_t;

    seq_t d, q;
    logic last_e, last_f;

    always_comb begin
        d            = q;
        d.frame_end  = 1'b0;
        d.block_end  = 1'b0;
        step_o       = 1'b0;
        frame_step_o = 1'b0;
        last_e       = (q.eidx == q.elast);
        last_f       = (q.fidx == q.flast);
        if (start_i) begin
            d.active = 1'b1;
            d.eidx   = '0;
            d.fidx   = '0;
            d.elast  = (elem_cnt_i  == '0) ? '0 : elem_cnt_i  - CNT_W'(1);
            d.flast  = (frame_cnt_i == '0) ? '0 : frame_cnt_i - CNT_W'(1);
        end else if (q.active && done_i) begin
            d.frame_end = last_e;
            if (last_e && last_f) begin
                d.active    = 1'b0;
                d.block_end = 1'b1;
            end else begin
                step_o       = 1'b1;
                frame_step_o = last_e;
                if (last_e) begin
                    d.eidx = '0;
                    d.fidx = q.fidx + CNT_W'(1);
                end else begin
                    d.eidx = q.eidx + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign active_o    = q.active;
    assign frame_end_o = q.frame_end;
    assign block_end_o = q.block_end;

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 16,
    parameter int CNT_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] src_start_i,
    input  logic [ADDR_W-1:0] dst_start_i,
    input  logic [1:0]        elem_size_i,
    input  logic [1:0]        src_mode_i,
    input  logic [1:0]        dst_mode_i,
    input  logic [OFS_W-1:0]  src_elem_ofs_i,
    input  logic [OFS_W-1:0]  src_frame_ofs_i,
    input  logic [OFS_W-1:0]  dst_elem_ofs_i,
    input  logic [OFS_W-1:0]  dst_frame_ofs_i,
    input  logic [CNT_W-1:0]  elem_cnt_i,
    input  logic [CNT_W-1:0]  frame_cnt_i,
    input  logic              elem_done_i,
    output logic [ADDR_W-1:0] src_addr_o,
    output logic [ADDR_W-1:0] dst_addr_o,
    output logic              active_o,
    output logic              frame_end_o,
    output logic              block_end_o,
    output logic              src_misalign_o,
    output logic              dst_misalign_o
);
    logic step, frame_step;

    dma_ag_seq #(.CNT_W(CNT_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .elem_cnt_i   (elem_cnt_i),
        .frame_cnt_i  (frame_cnt_i),
        .done_i       (elem_done_i),
        .active_o     (active_o),
        .step_o       (step),
        .frame_step_o (frame_step),
        .frame_end_o  (frame_end_o),
        .block_end_o  (block_end_o)
    );

    dma_ag_side #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_src (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_addr_i (src_start_i),
        .mode_i       (src_mode_i),
        .size_i       (elem_size_i),
        .elem_ofs_i   (src_elem_ofs_i),
        .frame_ofs_i  (src_frame_ofs_i),
        .step_i       (step),
        .frame_step_i (frame_step),
        .addr_o       (src_addr_o),
        .misalign_o   (src_misalign_o)
    );

    dma_ag_side #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_dst (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_addr_i (dst_start_i),
        .mode_i       (dst_mode_i),
        .size_i       (elem_size_i),
        .elem_ofs_i   (dst_elem_ofs_i),
        .frame_ofs_i  (dst_frame_ofs_i),
        .step_i       (step),
        .frame_step_i (frame_step),
        .addr_o       (dst_addr_o),
        .misalign_o   (dst_misalign_o)
    );

endmodule

// File: rtl/dma_ag_chk.sv
module dma_ag_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              elem_done_i,
    input logic [ADDR_W-1:0] src_start_i,
    input logic [ADDR_W-1:0] dst_start_i,
    input logic [1:0]        elem_size_i,
    input logic [ADDR_W-1:0] src_addr_o,
    input logic [ADDR_W-1:0] dst_addr_o,
    input logic              active_o,
    input logic              frame_end_o,
    input logic              block_end_o,
    input logic              src_misalign_o,
    input logic              dst_misalign_o
);
    logic [ADDR_W-1:0] size_mask;
    always_comb size_mask = (ADDR_W'(1) << elem_size_i) - ADDR_W'(1);

    assert_load_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (src_addr_o == $past(src_start_i)) && active_o);

    assert_load_dst_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (dst_addr_o == $past(dst_start_i)));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !active_o) |=> $stable(src_addr_o) && $stable(dst_addr_o)
                                    && !frame_end_o && !block_end_o && !active_o);

    assert_no_done_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !elem_done_i) |=> $stable(src_addr_o) && $stable(dst_addr_o)
                                       && !frame_end_o && $stable(active_o));

    assert_block_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        block_end_o |-> frame_end_o && !active_o);

    assert_block_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        block_end_o |-> $stable(src_addr_o) && $stable(dst_addr_o));

    assert_misalign_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> src_misalign_o == $past(|(src_start_i & size_mask)));

    assert_misalign_dst_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> dst_misalign_o == $past(|(dst_start_i & size_mask)));

    assert_misalign_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(src_misalign_o) && $stable(dst_misalign_o));

endmodule

bind dma_addr_gen dma_ag_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .elem_done_i    (elem_done_i),
    .src_start_i    (src_start_i),
    .dst_start_i    (dst_start_i),
    .elem_size_i    (elem_size_i),
    .src_addr_o     (src_addr_o),
    .dst_addr_o     (dst_addr_o),
    .active_o       (active_o),
    .frame_end_o    (frame_end_o),
    .block_end_o    (block_end_o),
    .src_misalign_o (src_misalign_o),
    .dst_misalign_o (dst_misalign_o)
);

// File: tb/tb_dma_addr_gen.sv
`timescale 1ns/1ps
module tb_dma_addr_gen;
    localparam int AW = 32;
    localparam int OW = 16;
    localparam int CW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] src_start_i = '0, dst_start_i = '0;
    logic [1:0]    elem_size_i = '0, src_mode_i = '0, dst_mode_i = '0;
    logic [OW-1:0] src_elem_ofs_i = '0, src_frame_ofs_i = '0;
    logic [OW-1:0] dst_elem_ofs_i = '0, dst_frame_ofs_i = '0;
    logic [CW-1:0] elem_cnt_i = '0, frame_cnt_i = '0;
    logic          elem_done_i = 1'b0;
    logic [AW-1:0] src_addr_o, dst_addr_o;
    logic          active_o, frame_end_o, block_end_o, src_misalign_o, dst_misalign_o;

    always #4 clk = ~clk;

    dma_addr_gen dut (.*);

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // bench model state
    logic [AW-1:0] m_src, m_dst;
    logic [1:0]    m_sz, m_sm, m_dm;
    logic [OW-1:0] m_se, m_sf, m_de, m_df;
    int            m_E, m_F, m_ei, m_fi;
    bit            m_act;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] delta(logic [1:0] mode, logic [1:0] sz,
                                            logic [OW-1:0] eo, logic [OW-1:0] fo, bit fr);
        case (mode)
            2'b01:   return AW'(1) << sz;
            2'b10:   return fr ? AW'(signed'(fo)) : AW'(signed'(eo));
            default: return '0;
        endcase
    endfunction

    task automatic check_state(string req);
        chk({req, " src_addr"}, 64'(src_addr_o), 64'(m_src));
        chk({req, " dst_addr"}, 64'(dst_addr_o), 64'(m_dst));
        chk({req, " active"}, 64'(active_o), 64'(m_act));
    endtask

    // called at a negedge; returns at a negedge with start low and setup scrambled (R12)
    task automatic do_start(logic [AW-1:0] sa, logic [AW-1:0] da, logic [1:0] sz,
                            logic [1:0] sm, logic [1:0] dm, int e, int f);
        logic [AW-1:0] mask;
        src_start_i = sa; dst_start_i = da; elem_size_i = sz;
        src_mode_i = sm; dst_mode_i = dm;
        src_elem_ofs_i = 16'h0010; src_frame_ofs_i = 16'hFF00;
        dst_elem_ofs_i = 16'hFFF8; dst_frame_ofs_i = 16'h0104;
        elem_cnt_i = CW'(e); frame_cnt_i = CW'(f);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        src_start_i = ~sa; dst_start_i = ~da; elem_size_i = ~sz;
        src_mode_i = ~sm; dst_mode_i = ~dm;
        src_elem_ofs_i = 16'h1234; src_frame_ofs_i = 16'h8001;
        dst_elem_ofs_i = 16'h0F0F; dst_frame_ofs_i = 16'h7777;
        elem_cnt_i = 13'd7; frame_cnt_i = 13'd5;
        m_src = sa; m_dst = da; m_sz = sz; m_sm = sm; m_dm = dm;
        m_se = 16'h0010; m_sf = 16'hFF00; m_de = 16'hFFF8; m_df = 16'h0104;
        m_E = (e == 0) ? 1 : e; m_F = (f == 0) ? 1 : f;
        m_ei = 0; m_fi = 0; m_act = 1;
        mask = (AW'(1) << sz) - AW'(1);
        check_state("R1 start load");
        chk("R10 src misalign", 64'(src_misalign_o), 64'(|(sa & mask)));
        chk("R10 dst misalign", 64'(dst_misalign_o), 64'(|(da & mask)));
    endtask

    // one element-done pulse; called and returns at a negedge
    task automatic do_elem(string req);
        bit le, lf;
        le = (m_ei == m_E - 1);
        lf = (m_fi == m_F - 1);
        elem_done_i = 1'b1;
        @(negedge clk);
        elem_done_i = 1'b0;
        if (m_act) begin
            if (le && lf) begin
                m_act = 0;
            end else begin
                m_src = m_src + delta(m_sm, m_sz, m_se, m_sf, le);
                m_dst = m_dst + delta(m_dm, m_sz, m_de, m_df, le);
                if (le) begin m_ei = 0; m_fi++; end
                else m_ei++;
            end
            chk({req, " R7 frame_end"}, 64'(frame_end_o), 64'(le));
            chk({req, " R8 block_end"}, 64'(block_end_o), 64'(le && lf));
        end else begin
            chk({req, " R11 idle frame_end"}, 64'(frame_end_o), 64'd0);
            chk({req, " R11 idle block_end"}, 64'(block_end_o), 64'd0);
        end
        check_state(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("reset src_addr", 64'(src_addr_o), 64'd0);
        chk("reset active", 64'(active_o), 64'd0);
        chk("reset flags", 64'({frame_end_o, block_end_o, src_misalign_o, dst_misalign_o}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 R6: every size against every mode pair, 3 elements x 2 frames
        for (int sz = 0; sz < 4; sz++)
            for (int sm = 0; sm < 4; sm++)
                for (int dm = 0; dm < 4; dm++) begin
                    do_start(32'h0000_1000, 32'h0000_8000, 2'(sz), 2'(sm), 2'(dm), 3, 2);
                    for (int k = 0; k < 6; k++) do_elem("R2 R3 R4 R5 R6 sweep");
                end

        // R11: element-done while idle changes nothing
        for (int k = 0; k < 3; k++) do_elem("R11 idle done");

        // R9: zero counts mean one element, one frame
        do_start(32'h0000_2000, 32'h0000_3000, 2'd2, 2'd1, 2'd2, 0, 0);
        do_elem("R9 zero counts");
        do_elem("R9 after end");

        // R9: one element per frame, three frames (every element hits a frame edge)
        do_start(32'h0000_4000, 32'h0000_5000, 2'd1, 2'd2, 2'd2, 1, 3);
        for (int k = 0; k < 4; k++) do_elem("R6 R9 single-element frames");

        // R11: gaps without element-done keep state
        do_start(32'h0000_6000, 32'h0000_7000, 2'd3, 2'd1, 2'd1, 4, 1);
        do_elem("R4 gap");
        repeat (3) @(negedge clk);
        check_state("R11 no-done gap");
        chk("R11 gap frame_end", 64'(frame_end_o), 64'd0);

        // R1: restart in the middle of a block
        do_start(32'h0000_A000, 32'h0000_B000, 2'd0, 2'd2, 2'd1, 2, 2);
        do_elem("R1 restart");
        for (int k = 0; k < 5; k++) do_elem("R1 restarted block");

        // R10: misalignment detection at several sizes
        do_start(32'h0000_1002, 32'h0000_1004, 2'd2, 2'd0, 2'd0, 1, 1);
        do_start(32'h0000_1003, 32'h0000_1001, 2'd0, 2'd0, 2'd0, 1, 1);
        do_start(32'h0000_1004, 32'h0000_1008, 2'd3, 2'd0, 2'd0, 1, 1);
        do_start(32'h0000_1002, 32'h0000_1003, 2'd1, 2'd0, 2'd0, 1, 1);
        do_elem("R10 block");
        chk("R10 flag held src", 64'(src_misalign_o), 64'd0);
        chk("R10 flag held dst", 64'(dst_misalign_o), 64'd1);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule